// File: doc/BRIEF.md
# UART Sleep and Auto-Wake Controller

This block decides when a UART core may stop its clock and when the clock must come back. It runs on a clock that never stops and drives a single clock-enable output for the gated part of the core. The controller has two ways into sleep. In the software-controlled way, a register enable bit allows sleep, and the block enters it only when the core is fully quiet. In the pin-controlled way, a dedicated sleep input forces sleep as soon as both shift registers are between characters.

In software mode, activity wakes the block and the clock returns. The wake sources are a start bit on the receive line, a write to the transmit holding register, or a level change on any modem input. Once every interrupt has been cleared, the block goes back to sleep by itself. Modem line changes are kept in sticky change bits. These bits hold the block awake until the modem status is read. An optional wake-up interrupt reports each return from sleep.

Top module: `uart_doze_ctrl`

## Requirements
- R1: After reset, clk_en_o is 1 and sleeping_o, wake_irq_o and modem_delta_o are all 0.
- R2: With sw_sleep_en_i=1, sleep_pin_i=0 and every entry condition met, sleeping_o goes to 1 and clk_en_o to 0 one clock later. The entry conditions are: irq_pending_i=0, both FIFO-empty flags 1, divisor_nz_i=1, modem_delta_o all 0, and RX at its idle level.
- R3: Software sleep is not entered while an interrupt is pending, either FIFO holds data, or the divisor is zero. It is entered once the blocking condition is removed.
- R4: The RX idle level is 1 when irda_mode_i=0 and 0 when irda_mode_i=1. Software sleep requires RX at that level.
- R5: In software sleep, an RX transition away from its idle level wakes the block on the next clock.
- R6: In software sleep, a one-cycle thr_write_i pulse wakes the block on the next clock.
- R7: A level change on modem_n_i[i] sets modem_delta_o[i] and wakes a sleeping block. The bit stays set until a msr_read_i pulse clears it. While any bit is set, software sleep is not entered.
- R8: After a wake-up, the block returns to software sleep by itself once irq_pending_i returns to 0 and the other conditions hold.
- R9: Writing sw_sleep_en_i=0 wakes the block and keeps it awake while sleep_pin_i=0.
- R10: With sleep_pin_i=1, the block sleeps once tsr_idle_i and rsr_idle_i are both 1, whatever the FIFO and interrupt state. RX and THR activity do not wake it. It wakes only when the pin returns to 0.
- R11: While sleep_pin_i=1 holds the block asleep, clearing sw_sleep_en_i does not wake it.
- R12: Every sleep-to-awake transition sets a sticky wake flag, and wake_status_read_i clears it. wake_irq_o is the flag gated by wake_irq_en_i, so it stays 0 while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_sleep_en_i | input | 1 | Software sleep enable bit |
| irq_pending_i | input | 1 | Any UART interrupt pending |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| rx_fifo_empty_i | input | 1 | Receive FIFO empty |
| divisor_nz_i | input | 1 | Baud divisor is non-zero |
| rx_line_i | input | 1 | Serial receive line level |
| irda_mode_i | input | 1 | Infrared mode, idle level low |
| modem_n_i | input | NUM_MODEM | Modem inputs, active low |
| thr_write_i | input | 1 | Transmit holding register write strobe |
| msr_read_i | input | 1 | Modem status read strobe |
| tsr_idle_i | input | 1 | Transmit shift register idle |
| rsr_idle_i | input | 1 | Receive shift register idle |
| sleep_pin_i | input | 1 | Hardware sleep request |
| wake_irq_en_i | input | 1 | Wake-up interrupt enable |
| wake_status_read_i | input | 1 | Wake status read strobe, clears flag |
| clk_en_o | output | 1 | Clock enable for the gated core |
| sleeping_o | output | 1 | Block is in a sleep state |
| wake_irq_o | output | 1 | Wake-up interrupt |
| modem_delta_o | output | NUM_MODEM | Sticky modem change bits |

## Verification
The hardest situation to reach is one where software and pin control overlap: the block is held asleep by the pin while the software enable is removed, and then the pin is released. The bench first puts the block into software sleep and asserts the pin with both shift registers idle. It then clears the enable and confirms the block is still asleep. Releasing the pin must then leave the block awake for good. A second hard case is a modem change that arrives during sleep: the block must stay awake until the status read, and that read must be followed by an automatic return to sleep.

// File: rtl/doze_pkg.sv
package doze_pkg;
   typedef enum logic [1:0] {
      DZ_AWAKE     = 2'd0,
      DZ_SW_SLEEP  = 2'd1,
      DZ_PIN_SLEEP = 2'd2
   } doze_state_e;
endpackage

// File: rtl/doze_line_watch.sv
module doze_line_watch #(
   parameter int NUM_MODEM = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 arm_i,
   input  logic [NUM_MODEM-1:0] line_i,
   input  logic                 clr_i,
   output logic                 change_o,
   output logic [NUM_MODEM-1:0] delta_o
);
   logic [NUM_MODEM-1:0] hist_q;
   logic [NUM_MODEM-1:0] diff;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '1;
      else         hist_q <= line_i;
   end

   for (genvar g = 0; g < NUM_MODEM; g++) begin : g_bit
      assign diff[g] = arm_i & (line_i[g] ^ hist_q[g]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       delta_o[g] <= 1'b0;
         else if (diff[g])  delta_o[g] <= 1'b1;
         else if (clr_i)    delta_o[g] <= 1'b0;
      end
   end

   assign change_o = |diff;
endmodule

// File: rtl/doze_rx_watch.sv
module doze_rx_watch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic rx_i,
   input  logic irda_i,
   output logic idle_o,
   output logic start_o
);
   logic rx_q;
   logic idle_lvl;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_q <= 1'b1;
      else         rx_q <= rx_i;
   end

   assign idle_lvl = ~irda_i;
   assign idle_o   = (rx_i == idle_lvl);
   assign start_o  = arm_i & (rx_q == idle_lvl) & (rx_i != idle_lvl);
endmodule

// File: rtl/doze_wake_flag.sv
module doze_wake_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic asleep_i,
   input  logic clr_i,
   input  logic en_i,
   output logic irq_o
);
   logic asleep_q;
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         asleep_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         asleep_q <= asleep_i;
         if (asleep_q && !asleep_i) flag_q <= 1'b1;
         else if (clr_i)            flag_q <= 1'b0;
      end
   end

   assign irq_o = flag_q & en_i;
endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl #(
   parameter int NUM_MODEM        = 4,
   parameter bit WAKE_IRQ_PRESENT = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 sw_sleep_en_i,
   input  logic                 irq_pending_i,
   input  logic                 tx_fifo_empty_i,
   input  logic                 rx_fifo_empty_i,
   input  logic                 divisor_nz_i,
   input  logic                 rx_line_i,
   input  logic                 irda_mode_i,
   input  logic [NUM_MODEM-1:0] modem_n_i,
   input  logic                 thr_write_i,
   input  logic                 msr_read_i,
   input  logic                 tsr_idle_i,
   input  logic                 rsr_idle_i,
   input  logic                 sleep_pin_i,
   input  logic                 wake_irq_en_i,
   input  logic                 wake_status_read_i,
   output logic                 clk_en_o,
   output logic                 sleeping_o,
   output logic                 wake_irq_o,
   output logic [NUM_MODEM-1:0] modem_delta_o
);
   import doze_pkg::*;

   if (NUM_MODEM < 1 || NUM_MODEM > 16) begin : g_bad_width
      $error("uart_doze_ctrl: NUM_MODEM out of range");
   end

   doze_state_e state_q, state_d;
   logic arm_q;
   logic modem_chg, rx_start, rx_idle;
   logic wake_evt, sw_ok, shifters_idle;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arm_q <= 1'b0;
      else         arm_q <= 1'b1;
   end

   doze_line_watch #(.NUM_MODEM(NUM_MODEM)) line_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm_q),
      .line_i   (modem_n_i),
      .clr_i    (msr_read_i),
      .change_o (modem_chg),
      .delta_o  (modem_delta_o)
   );

   doze_rx_watch rx_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (arm_q),
      .rx_i    (rx_line_i),
      .irda_i  (irda_mode_i),
      .idle_o  (rx_idle),
      .start_o (rx_start)
   );

   assign wake_evt      = rx_start | thr_write_i | modem_chg;
   assign shifters_idle = tsr_idle_i & rsr_idle_i;
   assign sw_ok = sw_sleep_en_i & ~irq_pending_i & tx_fifo_empty_i &
                  rx_fifo_empty_i & divisor_nz_i & rx_idle &
                  ~(|modem_delta_o) & ~wake_evt;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         DZ_AWAKE: begin
            if (sleep_pin_i) begin
               if (shifters_idle) state_d = DZ_PIN_SLEEP;
            end else if (sw_ok) begin
               state_d = DZ_SW_SLEEP;
            end
         end
         DZ_SW_SLEEP: begin
            if (sleep_pin_i)
               state_d = shifters_idle ? DZ_PIN_SLEEP : DZ_AWAKE;
            else if (wake_evt || !sw_sleep_en_i)
               state_d = DZ_AWAKE;
         end
         DZ_PIN_SLEEP: begin
            if (!sleep_pin_i) state_d = DZ_AWAKE;
         end
         default: state_d = DZ_AWAKE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= DZ_AWAKE;
      else         state_q <= state_d;
   end

   assign sleeping_o = (state_q != DZ_AWAKE);
   assign clk_en_o   = (state_q == DZ_AWAKE);

   if (WAKE_IRQ_PRESENT) begin : g_wake_irq
      doze_wake_flag flag_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .asleep_i (sleeping_o),
         .clr_i    (wake_status_read_i),
         .en_i     (wake_irq_en_i),
         .irq_o    (wake_irq_o)
      );
   end else begin : g_no_wake_irq
      logic unused_w;
      assign unused_w   = wake_irq_en_i ^ wake_status_read_i;
      assign wake_irq_o = 1'b0;
   end
endmodule

// File: rtl/doze_ctrl_chk.sv
module doze_ctrl_chk #(
   parameter int NUM_MODEM = 4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 sw_sleep_en_i,
   input logic                 irq_pending_i,
   input logic                 thr_write_i,
   input logic                 tsr_idle_i,
   input logic                 rsr_idle_i,
   input logic                 sleep_pin_i,
   input logic                 wake_irq_en_i,
   input logic                 clk_en_o,
   input logic                 sleeping_o,
   input logic                 wake_irq_o,
   input logic [NUM_MODEM-1:0] modem_delta_o
);
   a_r2_clk_matches_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_en_o != sleeping_o);

   a_r3_no_entry_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sleeping_o && irq_pending_i && !sleep_pin_i) |=> !sleeping_o);

   a_r6_thr_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleeping_o && thr_write_i && !sleep_pin_i) |=> !sleeping_o);

   a_r7_delta_keeps_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|modem_delta_o) && !sleep_pin_i) |=> !sleeping_o);

   a_r9_disable_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_sleep_en_i && !sleep_pin_i) |=> !sleeping_o);

   a_r10_pin_holds_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleeping_o && sleep_pin_i && tsr_idle_i && rsr_idle_i) |=> sleeping_o);

   a_r12_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wake_irq_en_i |-> !wake_irq_o);
endmodule

bind uart_doze_ctrl doze_ctrl_chk #(.NUM_MODEM(NUM_MODEM)) chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .sw_sleep_en_i (sw_sleep_en_i),
   .irq_pending_i (irq_pending_i),
   .thr_write_i   (thr_write_i),
   .tsr_idle_i    (tsr_idle_i),
   .rsr_idle_i    (rsr_idle_i),
   .sleep_pin_i   (sleep_pin_i),
   .wake_irq_en_i (wake_irq_en_i),
   .clk_en_o      (clk_en_o),
   .sleeping_o    (sleeping_o),
   .wake_irq_o    (wake_irq_o),
   .modem_delta_o (modem_delta_o)
);

// File: tb/uart_doze_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_doze_ctrl_tb_top;
   localparam int NM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_en = 0, irq = 0, txe = 1, rxe = 1, divnz = 1, rx = 1, irda = 0;
   logic [NM-1:0] modem = '1;
   logic thr = 0, msr_rd = 0, tsr_idle = 1, rsr_idle = 1, pin = 0;
   logic wk_en = 0, wk_rd = 0;
   logic clk_en, sleeping, wk_irq;
   logic [NM-1:0] delta;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_doze_ctrl #(.NUM_MODEM(NM)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sw_sleep_en_i(sw_en), .irq_pending_i(irq),
      .tx_fifo_empty_i(txe), .rx_fifo_empty_i(rxe), .divisor_nz_i(divnz),
      .rx_line_i(rx), .irda_mode_i(irda), .modem_n_i(modem), .thr_write_i(thr),
      .msr_read_i(msr_rd), .tsr_idle_i(tsr_idle), .rsr_idle_i(rsr_idle),
      .sleep_pin_i(pin), .wake_irq_en_i(wk_en), .wake_status_read_i(wk_rd),
      .clk_en_o(clk_en), .sleeping_o(sleeping), .wake_irq_o(wk_irq),
      .modem_delta_o(delta));

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go_sleep();
      sw_en = 1; step(2);
   endtask

   task automatic t_reset();
      chk("R1 clk_en", clk_en, 1); chk("R1 sleeping", sleeping, 0);
      chk("R1 wake_irq", wk_irq, 0); chk("R1 delta", delta, 0);
   endtask

   task automatic t_entry();
      sw_en = 1; step(1);
      chk("R2 sleeping", sleeping, 1); chk("R2 clk_en", clk_en, 0);
   endtask

   task automatic t_blockers();
      for (int k = 0; k < 4; k++) begin
         sw_en = 0; step(1);
         case (k)
            0: irq = 1;
            1: txe = 0;
            2: rxe = 0;
            default: divnz = 0;
         endcase
         sw_en = 1; step(3);
         chk($sformatf("R3 blocked case %0d", k), sleeping, 0);
         irq = 0; txe = 1; rxe = 1; divnz = 1; step(2);
         chk($sformatf("R3 released case %0d", k), sleeping, 1);
      end
   endtask

   task automatic t_irda();
      sw_en = 0; step(1);
      irda = 1; sw_en = 1; step(3);
      chk("R4 irda rx high not idle", sleeping, 0);
      rx = 0; step(2);
      chk("R4 irda rx low idle", sleeping, 1);
      rx = 1; step(1);
      chk("R5 irda start wakes", sleeping, 0);
      irda = 0; step(2);
      chk("R4 normal rx high idle", sleeping, 1);
   endtask

   task automatic t_rx_wake();
      rx = 0; step(1);
      chk("R5 start bit wakes", sleeping, 0);
      rx = 1; step(2);
      chk("R8 resleep after rx", sleeping, 1);
   endtask

   task automatic t_thr_wake();
      thr = 1; step(1); thr = 0;
      chk("R6 thr wakes", clk_en, 1);
      step(2);
      chk("R8 resleep after thr", sleeping, 1);
   endtask

   task automatic t_irq_resleep();
      thr = 1; irq = 1; step(1); thr = 0; step(3);
      chk("R8 awake while irq", sleeping, 0);
      irq = 0; step(2);
      chk("R8 resleep after irq clear", sleeping, 1);
   endtask

   task automatic t_modem();
      modem[2] = 1'b0; step(1);
      chk("R7 modem wakes", sleeping, 0); chk("R7 delta bit2", delta, 4'b0100);
      step(3);
      chk("R7 held awake", sleeping, 0); chk("R7 delta sticky", delta, 4'b0100);
      msr_rd = 1; step(1); msr_rd = 0;
      chk("R7 read clears", delta, 0);
      step(1);
      chk("R7 resleep after read", sleeping, 1);
      modem[2] = 1'b1; modem[0] = 1'b0; step(1);
      chk("R7 second change", delta, 4'b0101);
      msr_rd = 1; step(1); msr_rd = 0; step(1);
      chk("R7 resleep again", sleeping, 1);
      modem = '1; step(1); msr_rd = 1; step(1); msr_rd = 0; step(1);
   endtask

   task automatic t_disable();
      sw_en = 0; step(1);
      chk("R9 disable wakes", sleeping, 0);
      step(4);
      chk("R9 stays awake", clk_en, 1);
   endtask

   task automatic t_pin();
      rxe = 0; irq = 1; tsr_idle = 0; pin = 1; step(3);
      chk("R10 waits for shifter", sleeping, 0);
      tsr_idle = 1; step(1);
      chk("R10 pin sleep", sleeping, 1);
      thr = 1; rx = 0; step(1); thr = 0; rx = 1; step(1);
      chk("R10 ignores activity", sleeping, 1);
      pin = 0; step(1);
      chk("R10 pin release wakes", sleeping, 0);
      rxe = 1; irq = 0; step(1);
   endtask

   task automatic t_priority();
      go_sleep();
      chk("R11 sw sleep first", sleeping, 1);
      pin = 1; step(1); sw_en = 0; step(3);
      chk("R11 pin keeps sleep", sleeping, 1);
      pin = 0; step(3);
      chk("R11 awake after release", sleeping, 0);
   endtask

   task automatic t_wake_irq();
      wk_rd = 1; step(1); wk_rd = 0;
      go_sleep();
      thr = 1; step(1); thr = 0; sw_en = 0; step(2);
      chk("R12 gated off", wk_irq, 0);
      wk_en = 1; #1;
      chk("R12 flag raises irq", wk_irq, 1);
      step(1); wk_rd = 1; step(1); wk_rd = 0;
      chk("R12 read clears", wk_irq, 0);
      go_sleep();
      sw_en = 0; step(2);
      chk("R12 new wake sets", wk_irq, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; step(1);
      t_reset();
      t_entry();
      t_blockers();
      t_irda();
      t_rx_wake();
      t_thr_wake();
      t_irq_resleep();
      t_modem();
      t_disable();
      t_pin();
      t_priority();
      t_wake_irq();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule